// File: doc/BRIEF.md
# In-Memory Bubble Sorter with Shared Bus Routines

This block sorts a run of unsigned words that sit in an external memory. The memory is reached only through an AXI-Lite master port. A caller gives a base byte address and an element count, then pulses `start`. The block sorts the region in place into ascending order with bubble sort. It compares neighbours `i` and `i+1` and writes the pair back exchanged only when the lower one holds the larger value. The pass length shrinks by one after every pass. A pass that makes no exchange ends the sort early. When the sort ends, `done` pulses for one cycle.

One read routine (`S_RD_ADDR`, `S_RD_DATA`) and one write routine (`S_WR_REQ`, `S_WR_RESP`) serve every memory access. A calling state loads a return-state register with the state to resume at, and then jumps into the routine. The routine's last state loads the state register from that return register. The main states are as follows:
- `S_IDLE` moves to `S_SETUP` on `start`.
- `S_SETUP` moves to `S_FINISH` when the count is below two, and otherwise to `S_PASS_START`.
- `S_PASS_START` moves to `S_LOAD_A`.
- `S_LOAD_A` calls the read routine with return to `S_LOAD_B`.
- `S_LOAD_B` calls the read routine with return to `S_COMPARE`.
- `S_COMPARE` moves to `S_SWAP_LO` if the lower element is greater, and otherwise to `S_NEXT`.
- `S_SWAP_LO` calls the write routine with return to `S_SWAP_HI`.
- `S_SWAP_HI` calls the write routine with return to `S_NEXT`.
- `S_NEXT` moves to `S_PASS_END` after the last pair, and otherwise to `S_LOAD_A`.
- `S_PASS_END` moves to `S_PASS_START` when another pass is needed, and otherwise to `S_FINISH`.
- `S_FINISH` moves to `S_IDLE`.

A write response other than OKAY moves `S_WR_RESP` straight to `S_FINISH` with the error flag set.

Top module: `memsort_top`

## Requirements
- R1: `start` is taken only in `S_IDLE`. The block then latches `base_addr` and `elem_count`. A `start` while a sort runs has no effect on either region of memory.
- R2: An element count of 0 or 1 produces `done` without any read or write transaction.
- R3: When the sort ends, the words at byte addresses base + (DATA_W/8)*i, for i = 0 to N-1, are in ascending unsigned order and hold the same multiset of values.
- R4: A read keeps `m_arvalid` high with a stable `m_araddr` until `m_arready`. It then holds `m_rready` until `m_rvalid` and captures `m_rdata`.
- R5: A write raises `m_awvalid` and `m_wvalid` in the same cycle with `m_wstrb` all ones. Each valid stays high until its own ready is seen. `m_bready` is then held until `m_bvalid`.
- R6: A pair is written back, as two writes, only when the lower element is strictly greater than the upper one. Equal elements cause no write.
- R7: A pass with no exchange ends the sort. An already ascending region of N elements costs exactly 2*(N-1) reads and no writes. A strictly descending region costs N*(N-1) writes.
- R8: A write response other than OKAY (`m_bresp` not 2'b00) ends the sort. It produces `done` with `error` = 1 and no further write requests. `error` stays until the next accepted `start` clears it.
- R9: `done` is high for exactly one cycle per sort. After reset, `done`, `error` and all request valids are low.
- R10: Each read or write routine resumes at the state recorded in the return register when the routine was entered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a sort (taken in idle only) |
| base_addr | input | ADDR_W | Byte address of element 0 |
| elem_count | input | CNT_W | Number of elements |
| done | output | 1 | One-cycle end-of-sort pulse |
| error | output | 1 | Last sort stopped on a bad write response |
| m_araddr | output | ADDR_W | Read address |
| m_arvalid | output | 1 | Read address valid |
| m_arready | input | 1 | Read address ready |
| m_rdata | input | DATA_W | Read data |
| m_rvalid | input | 1 | Read data valid |
| m_rready | output | 1 | Read data ready |
| m_awaddr | output | ADDR_W | Write address |
| m_awvalid | output | 1 | Write address valid |
| m_awready | input | 1 | Write address ready |
| m_wdata | output | DATA_W | Write data |
| m_wstrb | output | DATA_W/8 | Write byte strobes |
| m_wvalid | output | 1 | Write data valid |
| m_wready | input | 1 | Write data ready |
| m_bresp | input | 2 | Write response code |
| m_bvalid | input | 1 | Write response valid |
| m_bready | output | 1 | Write response ready |

## Verification
The bench builds the block with ADDR_W = 16, DATA_W = 32 and CNT_W = 6. With these values a 64-word memory model covers several disjoint regions, so one bench can show that a `start` given while busy leaves a second region untouched. The 32-bit data keeps words with the top bit set, which checks that the compare is unsigned. The memory model gives randomly delayed ready and valid signals, and the address and write-data channels may be accepted in either order. It can also return an error on a chosen write, which reaches the early-stop path in the write routine.

// File: rtl/memsort_pkg.sv
package memsort_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_SETUP,
        S_PASS_START,
        S_LOAD_A,
        S_LOAD_B,
        S_COMPARE,
        S_SWAP_LO,
        S_SWAP_HI,
        S_NEXT,
        S_PASS_END,
        S_RD_ADDR,
        S_RD_DATA,
        S_WR_REQ,
        S_WR_RESP,
        S_FINISH
    } state_e;

    localparam logic [1:0] RESP_OKAY = 2'b00;

    typedef struct packed {
        logic ld_base;
        logic init_limit;
        logic dec_limit;
        logic clr_idx;
        logic inc_idx;
        logic ld_acc;
        logic acc_hi;
        logic cap_rd;
        logic clr_swapped;
        logic set_swapped;
    } dp_ctrl_t;

endpackage

// File: rtl/memsort_dp.sv
module memsort_dp
    import memsort_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  dp_ctrl_t          ctl,
    input  logic [ADDR_W-1:0] base_in,
    input  logic [CNT_W-1:0]  count_in,
    input  logic [DATA_W-1:0] rd_word,
    output logic [ADDR_W-1:0] acc_addr,
    output logic [DATA_W-1:0] wr_word,
    output logic              n_small,
    output logic              idx_last,
    output logic              lo_gt_hi,
    output logic              swapped,
    output logic              limit_one
);

    localparam int STRIDE_SHIFT = $clog2(DATA_W / 8);

    logic [ADDR_W-1:0] base_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  limit_q;
    logic [CNT_W-1:0]  idx_q;
    logic [DATA_W-1:0] lo_q;
    logic [DATA_W-1:0] hi_q;
    logic              acc_hi_q;
    logic              swapped_q;
    logic [CNT_W-1:0]  elem;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q    <= '0;
            cnt_q     <= '0;
            limit_q   <= '0;
            idx_q     <= '0;
            lo_q      <= '0;
            hi_q      <= '0;
            acc_hi_q  <= 1'b0;
            swapped_q <= 1'b0;
        end else begin
            if (ctl.ld_base) begin
                base_q <= base_in;
                cnt_q  <= count_in;
            end
            if (ctl.init_limit) begin
                limit_q <= cnt_q - CNT_W'(1);
            end else if (ctl.dec_limit) begin
                limit_q <= limit_q - CNT_W'(1);
            end
            if (ctl.clr_idx) begin
                idx_q <= '0;
            end else if (ctl.inc_idx) begin
                idx_q <= idx_q + CNT_W'(1);
            end
            if (ctl.ld_acc) begin
                acc_hi_q <= ctl.acc_hi;
            end
            if (ctl.cap_rd) begin
                if (acc_hi_q) begin
                    hi_q <= rd_word;
                end else begin
                    lo_q <= rd_word;
                end
            end
            if (ctl.clr_swapped) begin
                swapped_q <= 1'b0;
            end else if (ctl.set_swapped) begin
                swapped_q <= 1'b1;
            end
        end
    end

    always_comb begin
        elem      = idx_q + CNT_W'(acc_hi_q);
        acc_addr  = base_q + (ADDR_W'(elem) << STRIDE_SHIFT);
        wr_word   = acc_hi_q ? lo_q : hi_q;
        n_small   = (cnt_q < CNT_W'(2));
        idx_last  = ((idx_q + CNT_W'(1)) == limit_q);
        lo_gt_hi  = (lo_q > hi_q);
        swapped   = swapped_q;
        limit_one = (limit_q == CNT_W'(1));
    end

    // R7: the pass length never shrinks below one pair
    a_r7_limit_floor: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.dec_limit |-> (limit_q > CNT_W'(1)));

    // R3: every access stays inside the region being sorted
    a_r3_idx_range: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.ld_acc |-> (idx_q < limit_q) && (limit_q < cnt_q));

endmodule

// File: rtl/memsort_ctrl.sv
module memsort_ctrl
    import memsort_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       n_small,
    input  logic       idx_last,
    input  logic       lo_gt_hi,
    input  logic       swapped,
    input  logic       limit_one,
    input  logic       arready,
    input  logic       rvalid,
    input  logic       awready,
    input  logic       wready,
    input  logic       bvalid,
    input  logic [1:0] bresp,
    output dp_ctrl_t   ctl,
    output logic       arvalid,
    output logic       rready,
    output logic       awvalid,
    output logic       wvalid,
    output logic       bready,
    output logic       done,
    output logic       error
);

    state_e state_q, state_d, nxt_fixed;
    state_e ret_q, ret_pick;
    logic   ret_ld;
    logic   take_ret;
    logic   aw_done_q, w_done_q;
    logic   clr_wr;
    logic   err_q, set_err, clr_err;

    // state register, return register and write-channel progress
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= S_IDLE;
            ret_q     <= S_IDLE;
            aw_done_q <= 1'b0;
            w_done_q  <= 1'b0;
            err_q     <= 1'b0;
        end else begin
            state_q <= state_d;
            if (ret_ld) begin
                ret_q <= ret_pick;
            end
            if (clr_wr) begin
                aw_done_q <= 1'b0;
                w_done_q  <= 1'b0;
            end else if (state_q == S_WR_REQ) begin
                if (awvalid && awready) aw_done_q <= 1'b1;
                if (wvalid && wready)   w_done_q  <= 1'b1;
            end
            if (clr_err) begin
                err_q <= 1'b0;
            end else if (set_err) begin
                err_q <= 1'b1;
            end
        end
    end

    assign state_d = take_ret ? ret_q : nxt_fixed;
    assign error   = err_q;

    // next state and outputs
    always_comb begin
        nxt_fixed = state_q;
        take_ret  = 1'b0;
        ret_ld    = 1'b0;
        ret_pick  = S_IDLE;
        ctl       = '0;
        arvalid   = 1'b0;
        rready    = 1'b0;
        awvalid   = 1'b0;
        wvalid    = 1'b0;
        bready    = 1'b0;
        done      = 1'b0;
        clr_wr    = 1'b0;
        set_err   = 1'b0;
        clr_err   = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                if (start) begin
                    ctl.ld_base = 1'b1;
                    clr_err     = 1'b1;
                    nxt_fixed   = S_SETUP;
                end
            end
            S_SETUP: begin
                if (n_small) begin
                    nxt_fixed = S_FINISH;
                end else begin
                    ctl.init_limit = 1'b1;
                    nxt_fixed      = S_PASS_START;
                end
            end
            S_PASS_START: begin
                ctl.clr_idx     = 1'b1;
                ctl.clr_swapped = 1'b1;
                nxt_fixed       = S_LOAD_A;
            end
            S_LOAD_A: begin
                ctl.ld_acc = 1'b1;
                ctl.acc_hi = 1'b0;
                ret_ld     = 1'b1;
                ret_pick   = S_LOAD_B;
                nxt_fixed  = S_RD_ADDR;
            end
            S_LOAD_B: begin
                ctl.ld_acc = 1'b1;
                ctl.acc_hi = 1'b1;
                ret_ld     = 1'b1;
                ret_pick   = S_COMPARE;
                nxt_fixed  = S_RD_ADDR;
            end
            S_COMPARE: begin
                nxt_fixed = lo_gt_hi ? S_SWAP_LO : S_NEXT;
            end
            S_SWAP_LO: begin
                ctl.ld_acc = 1'b1;
                ctl.acc_hi = 1'b0;
                ret_ld     = 1'b1;
                ret_pick   = S_SWAP_HI;
                clr_wr     = 1'b1;
                nxt_fixed  = S_WR_REQ;
            end
            S_SWAP_HI: begin
                ctl.ld_acc      = 1'b1;
                ctl.acc_hi      = 1'b1;
                ctl.set_swapped = 1'b1;
                ret_ld          = 1'b1;
                ret_pick        = S_NEXT;
                clr_wr          = 1'b1;
                nxt_fixed       = S_WR_REQ;
            end
            S_NEXT: begin
                if (idx_last) begin
                    nxt_fixed = S_PASS_END;
                end else begin
                    ctl.inc_idx = 1'b1;
                    nxt_fixed   = S_LOAD_A;
                end
            end
            S_PASS_END: begin
                if (swapped && !limit_one) begin
                    ctl.dec_limit = 1'b1;
                    nxt_fixed     = S_PASS_START;
                end else begin
                    nxt_fixed = S_FINISH;
                end
            end
            S_RD_ADDR: begin
                arvalid = 1'b1;
                if (arready) nxt_fixed = S_RD_DATA;
            end
            S_RD_DATA: begin
                rready = 1'b1;
                if (rvalid) begin
                    ctl.cap_rd = 1'b1;
                    take_ret   = 1'b1;
                end
            end
            S_WR_REQ: begin
                awvalid = !aw_done_q;
                wvalid  = !w_done_q;
                if ((aw_done_q || awready) && (w_done_q || wready)) begin
                    nxt_fixed = S_WR_RESP;
                end
            end
            S_WR_RESP: begin
                bready = 1'b1;
                if (bvalid) begin
                    if (bresp != RESP_OKAY) begin
                        set_err   = 1'b1;
                        nxt_fixed = S_FINISH;
                    end else begin
                        take_ret = 1'b1;
                    end
                end
            end
            S_FINISH: begin
                done      = 1'b1;
                nxt_fixed = S_IDLE;
            end
            default: nxt_fixed = S_IDLE;
        endcase
    end

    // R10: the read routine resumes where its caller pointed
    a_r10_read_return: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_RD_DATA) && rvalid |=> (state_q == $past(ret_q)));

    // R10: the write routine resumes where its caller pointed on OKAY
    a_r10_write_return: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_WR_RESP) && bvalid && (bresp == RESP_OKAY)
        |=> (state_q == $past(ret_q)));

    // R9: done lasts one cycle
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8: a raised error flag is followed immediately by the end of the sort
    a_r8_err_stop: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_q) |-> (state_q == S_FINISH));

    // R5: write-channel valids drop only after their ready
    a_r5_aw_hold: assert property (@(posedge clk) disable iff (!rst_n)
        awvalid && !awready |=> awvalid);
    a_r5_w_hold: assert property (@(posedge clk) disable iff (!rst_n)
        wvalid && !wready |=> wvalid);

    // R4: read address valid held until accepted
    a_r4_ar_hold: assert property (@(posedge clk) disable iff (!rst_n)
        arvalid && !arready |=> arvalid);

endmodule

// File: rtl/memsort_top.sv
module memsort_top
    import memsort_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic [ADDR_W-1:0]     base_addr,
    input  logic [CNT_W-1:0]      elem_count,
    output logic                  done,
    output logic                  error,
    output logic [ADDR_W-1:0]     m_araddr,
    output logic                  m_arvalid,
    input  logic                  m_arready,
    input  logic [DATA_W-1:0]     m_rdata,
    input  logic                  m_rvalid,
    output logic                  m_rready,
    output logic [ADDR_W-1:0]     m_awaddr,
    output logic                  m_awvalid,
    input  logic                  m_awready,
    output logic [DATA_W-1:0]     m_wdata,
    output logic [DATA_W/8-1:0]   m_wstrb,
    output logic                  m_wvalid,
    input  logic                  m_wready,
    input  logic [1:0]            m_bresp,
    input  logic                  m_bvalid,
    output logic                  m_bready
);

    localparam int STRB_W = DATA_W / 8;

    dp_ctrl_t          ctl;
    logic [ADDR_W-1:0] acc_addr;
    logic [DATA_W-1:0] wr_word;
    logic              n_small, idx_last, lo_gt_hi, swapped, limit_one;

    memsort_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .n_small   (n_small),
        .idx_last  (idx_last),
        .lo_gt_hi  (lo_gt_hi),
        .swapped   (swapped),
        .limit_one (limit_one),
        .arready   (m_arready),
        .rvalid    (m_rvalid),
        .awready   (m_awready),
        .wready    (m_wready),
        .bvalid    (m_bvalid),
        .bresp     (m_bresp),
        .ctl       (ctl),
        .arvalid   (m_arvalid),
        .rready    (m_rready),
        .awvalid   (m_awvalid),
        .wvalid    (m_wvalid),
        .bready    (m_bready),
        .done      (done),
        .error     (error)
    );

    memsort_dp #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .CNT_W  (CNT_W)
    ) u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl       (ctl),
        .base_in   (base_addr),
        .count_in  (elem_count),
        .rd_word   (m_rdata),
        .acc_addr  (acc_addr),
        .wr_word   (wr_word),
        .n_small   (n_small),
        .idx_last  (idx_last),
        .lo_gt_hi  (lo_gt_hi),
        .swapped   (swapped),
        .limit_one (limit_one)
    );

    assign m_araddr = acc_addr;
    assign m_awaddr = acc_addr;
    assign m_wdata  = wr_word;
    assign m_wstrb  = {STRB_W{1'b1}};

    // R4: read address stable while waiting for acceptance
    a_r4_araddr_stable: assert property (@(posedge clk) disable iff (!rst_n)
        m_arvalid && !m_arready |=> $stable(m_araddr));

    // R5: write address and data stable while waiting for acceptance
    a_r5_awaddr_stable: assert property (@(posedge clk) disable iff (!rst_n)
        m_awvalid && !m_awready |=> $stable(m_awaddr));
    a_r5_wdata_stable: assert property (@(posedge clk) disable iff (!rst_n)
        m_wvalid && !m_wready |=> $stable(m_wdata));

    // R5: the two write-side valids start together
    a_r5_valid_pair: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(m_awvalid) |-> $rose(m_wvalid));

endmodule

// File: tb/memsort_tb.sv
module memsort_top_tb_top;

    localparam int ADDR_W = 16;
    localparam int DATA_W = 32;
    localparam int CNT_W  = 6;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [ADDR_W-1:0] base_addr = '0;
    logic [CNT_W-1:0]  elem_count = '0;
    logic              done, error;
    logic [ADDR_W-1:0] m_araddr, m_awaddr;
    logic              m_arvalid, m_rready, m_awvalid, m_wvalid, m_bready;
    logic              m_arready = 1'b0, m_rvalid = 1'b0;
    logic              m_awready = 1'b0, m_wready = 1'b0, m_bvalid = 1'b0;
    logic [DATA_W-1:0] m_rdata = '0, m_wdata;
    logic [3:0]        m_wstrb;
    logic [1:0]        m_bresp = 2'b00;

    always #2.5 clk = ~clk;

    memsort_top #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr),
        .elem_count(elem_count), .done(done), .error(error),
        .m_araddr(m_araddr), .m_arvalid(m_arvalid), .m_arready(m_arready),
        .m_rdata(m_rdata), .m_rvalid(m_rvalid), .m_rready(m_rready),
        .m_awaddr(m_awaddr), .m_awvalid(m_awvalid), .m_awready(m_awready),
        .m_wdata(m_wdata), .m_wstrb(m_wstrb), .m_wvalid(m_wvalid),
        .m_wready(m_wready), .m_bresp(m_bresp), .m_bvalid(m_bvalid),
        .m_bready(m_bready)
    );

    // memory model with random handshake delays
    logic [DATA_W-1:0] mem [64];
    logic [15:0]       lfsr = 16'hACE1;
    logic              rd_pend = 1'b0, aw_got = 1'b0, w_got = 1'b0;
    logic [DATA_W-1:0] rd_word = '0, w_data = '0;
    logic [ADDR_W-1:0] aw_addr = '0;
    int                rd_cnt = 0, aw_cnt = 0, b_cnt = 0, proto_err = 0;
    int                err_at = -1;
    logic              p_arv = 0, p_arr = 0, p_awv = 0, p_awr = 0, p_wv = 0, p_wr = 0;
    logic [ADDR_W-1:0] p_araddr = '0;

    always @(posedge clk) begin
        lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        p_arv <= m_arvalid; p_arr <= m_arready; p_araddr <= m_araddr;
        p_awv <= m_awvalid; p_awr <= m_awready;
        p_wv  <= m_wvalid;  p_wr  <= m_wready;
        if (rst_n) begin
            if (p_arv && !p_arr && (!m_arvalid || m_araddr != p_araddr)) proto_err <= proto_err + 1;
            if (p_awv && !p_awr && !m_awvalid) proto_err <= proto_err + 1;
            if (p_wv && !p_wr && !m_wvalid) proto_err <= proto_err + 1;
            if (m_awvalid && !p_awv && !(m_wvalid && !p_wv)) proto_err <= proto_err + 1;
            if (m_wvalid && m_wstrb != 4'hF) proto_err <= proto_err + 1;
        end
        if (m_arvalid && m_arready) begin
            rd_pend <= 1'b1; rd_word <= mem[m_araddr[7:2]];
            rd_cnt <= rd_cnt + 1; m_arready <= 1'b0;
        end else begin
            m_arready <= m_arvalid && !rd_pend && !m_rvalid && lfsr[0];
        end
        if (m_rvalid && m_rready) m_rvalid <= 1'b0;
        else if (rd_pend && lfsr[1]) begin
            m_rvalid <= 1'b1; m_rdata <= rd_word; rd_pend <= 1'b0;
        end
        if (m_awvalid && m_awready) begin
            aw_got <= 1'b1; aw_addr <= m_awaddr; aw_cnt <= aw_cnt + 1; m_awready <= 1'b0;
        end else begin
            m_awready <= m_awvalid && !aw_got && lfsr[2];
        end
        if (m_wvalid && m_wready) begin
            w_got <= 1'b1; w_data <= m_wdata; m_wready <= 1'b0;
        end else begin
            m_wready <= m_wvalid && !w_got && lfsr[3];
        end
        if (m_bvalid && m_bready) m_bvalid <= 1'b0;
        else if (aw_got && w_got && !m_bvalid && lfsr[4]) begin
            if (b_cnt == err_at) m_bresp <= 2'b10;
            else begin
                m_bresp <= 2'b00;
                mem[aw_addr[7:2]] <= w_data;
            end
            m_bvalid <= 1'b1; b_cnt <= b_cnt + 1;
            aw_got <= 1'b0; w_got <= 1'b0;
        end
    end

    int n_checks = 0, n_fail = 0;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic load(input int w0, input int n, input logic [DATA_W-1:0] v []);
        for (int k = 0; k < n; k++) mem[w0 + k] = v[k];
    endtask

    // checks region ascending and equal to a bench-sorted copy
    task automatic chk_sorted(input int w0, input int n, input logic [DATA_W-1:0] v [], input string req);
        logic [DATA_W-1:0] e [];
        logic [DATA_W-1:0] t;
        bit ok;
        e = new[n];
        for (int k = 0; k < n; k++) e[k] = v[k];
        for (int a = 1; a < n; a++)
            for (int b = a; b > 0 && e[b-1] > e[b]; b--) begin
                t = e[b]; e[b] = e[b-1]; e[b-1] = t;
            end
        ok = 1'b1;
        for (int k = 0; k < n; k++) if (mem[w0 + k] !== e[k]) begin
            ok = 1'b0;
            chk(1'b0, req, longint'(mem[w0 + k]), longint'(e[k]));
        end
        if (ok) chk(1'b1, req, 0, 0);
    endtask

    task automatic run_sort(input logic [ADDR_W-1:0] base, input int n,
                            output bit got, output bit err_seen);
        got = 1'b0; err_seen = 1'b0;
        @(negedge clk);
        start = 1'b1; base_addr = base; elem_count = CNT_W'(n);
        @(negedge clk);
        start = 1'b0;
        for (int c = 0; c < 20000 && !got; c++) begin
            if (done) begin got = 1'b1; err_seen = error; end
            else @(negedge clk);
        end
        chk(got, "R9 done seen", got, 1);
        @(negedge clk);
        chk(!done, "R9 done one cycle", done, 0);
    endtask

    task automatic t_reset();
        chk(!done && !error, "R9 reset outputs", {done, error}, 0);
        chk(!m_arvalid && !m_awvalid && !m_wvalid, "R9 reset valids",
            {m_arvalid, m_awvalid, m_wvalid}, 0);
    endtask

    task automatic t_trivial();
        bit g, e;
        int r0, a0;
        for (int n = 0; n < 2; n++) begin
            r0 = rd_cnt; a0 = aw_cnt;
            run_sort(16'h0000, n, g, e);
            chk(rd_cnt == r0, "R2 no reads", rd_cnt - r0, 0);
            chk(aw_cnt == a0, "R2 no writes", aw_cnt - a0, 0);
        end
    endtask

    task automatic t_mixed();
        logic [DATA_W-1:0] v [] = '{32'h8000_0000, 32'd5, 32'hFFFF_FFFF, 32'd0, 32'd5,
                                    32'h7FFF_FFFF, 32'd123, 32'h8000_0001, 32'd1,
                                    32'hDEAD_BEEF, 32'd0, 32'd77};
        bit g, e;
        load(16, 12, v);
        run_sort(16'h0040, 12, g, e);
        chk_sorted(16, 12, v, "R3 R10 unsigned mixed");
        chk(!e, "R8 no error", e, 0);
        chk(proto_err == 0, "R4 R5 handshake rules", proto_err, 0);
    endtask

    task automatic t_ascending();
        logic [DATA_W-1:0] v [] = '{1, 2, 3, 10, 20, 30, 40, 50};
        bit g, e;
        int r0, a0;
        load(16, 8, v);
        r0 = rd_cnt; a0 = aw_cnt;
        run_sort(16'h0040, 8, g, e);
        chk(rd_cnt - r0 == 14, "R7 one pass reads", rd_cnt - r0, 14);
        chk(aw_cnt == a0, "R7 no writes", aw_cnt - a0, 0);
    endtask

    task automatic t_descending();
        logic [DATA_W-1:0] v [] = '{60, 50, 40, 30, 20, 10};
        bit g, e;
        int r0, a0;
        load(32, 6, v);
        r0 = rd_cnt; a0 = aw_cnt;
        run_sort(16'h0080, 6, g, e);
        chk(aw_cnt - a0 == 30, "R7 descending writes", aw_cnt - a0, 30);
        chk(rd_cnt - r0 == 30, "R7 descending reads", rd_cnt - r0, 30);
        chk_sorted(32, 6, v, "R3 descending");
    endtask

    task automatic t_equal();
        logic [DATA_W-1:0] v [] = '{9, 9, 9, 9, 9};
        bit g, e;
        int r0, a0;
        load(0, 5, v);
        r0 = rd_cnt; a0 = aw_cnt;
        run_sort(16'h0000, 5, g, e);
        chk(aw_cnt == a0, "R6 equal no swap", aw_cnt - a0, 0);
        chk(rd_cnt - r0 == 8, "R6 equal reads", rd_cnt - r0, 8);
    endtask

    task automatic t_error();
        logic [DATA_W-1:0] v [] = '{60, 50, 40, 30, 20, 10};
        logic [DATA_W-1:0] s [] = '{1, 2, 3};
        bit g, e;
        int a0;
        load(32, 6, v);
        a0 = aw_cnt;
        err_at = b_cnt + 2;
        run_sort(16'h0080, 6, g, e);
        chk(e, "R8 error flag", e, 1);
        chk(aw_cnt - a0 == 3, "R8 writes before stop", aw_cnt - a0, 3);
        repeat (20) @(negedge clk);
        chk(aw_cnt - a0 == 3 && !m_awvalid, "R8 quiet after stop", aw_cnt - a0, 3);
        chk(error, "R8 error held", error, 1);
        err_at = -1;
        load(0, 3, s);
        run_sort(16'h0000, 3, g, e);
        chk(!e, "R8 error cleared by start", e, 0);
    endtask

    task automatic t_busy_start();
        logic [DATA_W-1:0] va [] = '{8, 7, 6, 5, 4, 3, 2, 1};
        logic [DATA_W-1:0] vb [] = '{80, 70, 60, 50, 40, 30, 20, 10};
        bit g;
        bit ok;
        load(16, 8, va);
        load(0, 8, vb);
        @(negedge clk);
        start = 1'b1; base_addr = 16'h0040; elem_count = 6'd8;
        @(negedge clk);
        start = 1'b0;
        repeat (30) @(negedge clk);
        start = 1'b1; base_addr = 16'h0000; elem_count = 6'd8;
        @(negedge clk);
        start = 1'b0;
        g = 1'b0;
        for (int c = 0; c < 20000 && !g; c++) begin
            if (done) g = 1'b1; else @(negedge clk);
        end
        chk(g, "R1 first sort done", g, 1);
        chk_sorted(16, 8, va, "R1 active region sorted");
        ok = 1'b1;
        for (int k = 0; k < 8; k++) if (mem[k] !== vb[k]) ok = 1'b0;
        chk(ok, "R1 ignored start left region", ok, 1);
        repeat (5) @(negedge clk);
    endtask

    initial begin
        for (int k = 0; k < 64; k++) mem[k] = '0;
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_trivial();
        t_mixed();
        t_ascending();
        t_descending();
        t_equal();
        t_busy_start();
        t_error();
        chk(proto_err == 0, "R4 R5 handshake rules overall", proto_err, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule